// File: doc/BRIEF.md
# Programmable TFT Panel Timing Generator

This block produces the timing for a parallel RGB TFT panel. It derives a pixel clock from the system clock through a programmable divider. It scans every frame left to right within a line and top to bottom within the frame. For each position it drives line sync, frame sync and a data-enable strobe, together with the column and row of the active pixel being shown. All counters run in the system clock domain. They advance on a one-cycle enable pulse that the divider issues once per pixel period.

Software-style inputs set the geometry:
- the divider value;
- the active width and height, each written as the real count minus one;
- the sync width, back porch and front porch of a line, in pixel periods;
- the same three quantities for a frame, in whole lines.

Each line runs sync, then back porch, then active pixels, then front porch. A frame uses the same order counted in lines. The geometry is sampled once per frame, so a change written mid-frame cannot tear the current picture. Three invert bits set the resting level of the pixel clock, line sync and frame sync. A video-enable input gates all activity.

Top module: `tft_timing_gen`

## Requirements
- R1: The pixel clock period is 2*(clk_div+1) system cycles, and its non-inverted high phase lasts clk_div+1 cycles. When video is off, pclk_o rests at the level of pclk_inv.
- R2: Active width and height are programmed as the count minus one. h_act_m1=4 gives 5 pixel periods of data enable per line, and v_act_m1=2 gives 3 enabled lines per frame.
- R3: The line sync pulse lasts h_sync pixel periods. Data enable rises h_back pixel periods after line sync ends. The next line sync starts h_front pixel periods after data enable falls. The line repeats every h_sync+h_back+h_act_m1+1+h_front pixel periods.
- R4: The frame sync pulse lasts v_sync whole lines. The frame repeats every v_sync+v_back+v_act_m1+1+v_front lines.
- R5: An invert bit of 1 makes the matching output (pclk_o, hsync_o, vsync_o) active low and makes it rest high while idle. An invert bit of 0 gives active high with a low rest level.
- R6: While video_en is 0, the outputs are idle: syncs at their rest level, de_o=0, col_o=row_o=0. Setting video_en to 1 starts a frame at once, with line and frame sync both asserted.
- R7: While de_o=1, col_o counts 0..h_act_m1 across a line and row_o counts 0..v_act_m1 down the frame. While de_o=0, both read 0.
- R8: de_o is 1 only when both the line position and the frame position are in their active regions. It is therefore never 1 while either sync is asserted.
- R9: Geometry and divider inputs written during a frame take effect only from the start of the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| video_en | input | 1 | Enables scanning and outputs |
| clk_div | input | 8 | Divider value; pixel period is 2*(clk_div+1) |
| h_act_m1 | input | 11 | Active pixels per line minus one |
| h_front | input | 8 | Line front porch, pixel periods |
| h_back | input | 8 | Line back porch, pixel periods |
| h_sync | input | 8 | Line sync width, pixel periods (at least 1) |
| v_act_m1 | input | 11 | Active lines per frame minus one |
| v_front | input | 8 | Frame front porch, lines |
| v_back | input | 8 | Frame back porch, lines |
| v_sync | input | 8 | Frame sync width, lines (at least 1) |
| pclk_inv | input | 1 | Invert pixel clock |
| hsync_inv | input | 1 | Line sync active low |
| vsync_inv | input | 1 | Frame sync active low |
| pclk_o | output | 1 | Pixel clock |
| hsync_o | output | 1 | Line sync |
| vsync_o | output | 1 | Frame sync |
| de_o | output | 1 | Data enable |
| col_o | output | 11 | Active column |
| row_o | output | 11 | Active row |

## Verification
The bench measures the pixel clock period for several divider values. A design that drops the factor of two, or the +1, would give periods of clk_div+1 or 2*clk_div. It measures the porch gaps on both sides of the active region. A design that swaps porch order or treats the active size as the real count would show a gap or a data-enable run that is one pixel period off. It rewrites the active width mid-frame and expects the old run until the next frame sync; a design that applies inputs live would shorten the line at once. It also checks the inverted rest levels and the immediate return to idle when video is turned off.

// File: rtl/tft_timing_pkg.sv
// Package: shared widths and the per-axis geometry record used by the
// timing generator. Assumes both axes share one active-size width.
package tft_timing_pkg;
    parameter int DIV_W   = 8;   // divider value width
    parameter int ACT_W   = 11;  // active size / position width
    parameter int PORCH_W = 8;   // porch and sync width

    typedef struct packed {
        logic [PORCH_W-1:0] sync_w;
        logic [PORCH_W-1:0] back_p;
        logic [ACT_W-1:0]   act_m1;
        logic [PORCH_W-1:0] front_p;
    } axis_cfg_t;
endpackage

// File: rtl/tft_pclk_div.sv
// Pixel clock divider: toggles the raw pixel clock every DIV+1 system
// cycles and emits a one-cycle tick as the raw clock falls, once per
// pixel period of 2*(DIV+1) cycles. Held at rest while run is low.
module tft_pclk_div #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [DW-1:0] div,
    output logic          tick,
    output logic          pclk_raw
);
    logic [DW-1:0] cnt;
    logic          at_end;

    assign at_end = (cnt == div);
    assign tick   = run && at_end && pclk_raw;

    // Half-period counter and raw clock phase.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt      <= '0;
            pclk_raw <= 1'b0;
        end else if (at_end) begin
            cnt      <= '0;
            pclk_raw <= ~pclk_raw;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/tft_scan_axis.sv
// One scan axis (line or frame): a position counter running through
// sync, back porch, active and front porch regions in that order.
// Advances on step and reports a wrap on the step that leaves the
// last position. Assumes sync_w >= 1.
module tft_scan_axis #(
    parameter int W  = 11,
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          step,
    input  logic [PW-1:0] sync_w,
    input  logic [PW-1:0] back_p,
    input  logic [W-1:0]  act_m1,
    input  logic [PW-1:0] front_p,
    output logic          wrap,
    output logic          in_sync,
    output logic          in_act,
    output logic [W-1:0]  idx
);
    localparam int CW = W + 1;

    logic [CW-1:0] pos, act_lo, act_hi, last;

    // Region boundaries from the geometry.
    always_comb begin
        act_lo = CW'(sync_w) + CW'(back_p);
        act_hi = act_lo + CW'(act_m1);
        last   = act_hi + CW'(front_p);
    end

    assign wrap    = step && (pos == last);
    assign in_sync = (pos < CW'(sync_w));
    assign in_act  = (pos >= act_lo) && (pos <= act_hi);
    assign idx     = in_act ? W'(pos - act_lo) : '0;

    // Position counter.
    always_ff @(posedge clk) begin
        if (!rst_n || clear)
            pos <= '0;
        else if (step)
            pos <= wrap ? '0 : pos + 1'b1;
    end
endmodule

// File: rtl/tft_timing_gen.sv
// Top: TFT timing generator. Holds a frame-aligned copy of the timing
// inputs, drives the divider and the line and frame axes, and applies
// polarity and the video enable to the outputs. Single clock domain.
module tft_timing_gen
    import tft_timing_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               video_en,
    input  logic [DIV_W-1:0]   clk_div,
    input  logic [ACT_W-1:0]   h_act_m1,
    input  logic [PORCH_W-1:0] h_front,
    input  logic [PORCH_W-1:0] h_back,
    input  logic [PORCH_W-1:0] h_sync,
    input  logic [ACT_W-1:0]   v_act_m1,
    input  logic [PORCH_W-1:0] v_front,
    input  logic [PORCH_W-1:0] v_back,
    input  logic [PORCH_W-1:0] v_sync,
    input  logic               pclk_inv,
    input  logic               hsync_inv,
    input  logic               vsync_inv,
    output logic               pclk_o,
    output logic               hsync_o,
    output logic               vsync_o,
    output logic               de_o,
    output logic [ACT_W-1:0]   col_o,
    output logic [ACT_W-1:0]   row_o
);
    axis_cfg_t        h_cfg, v_cfg;
    logic [DIV_W-1:0] div_q;
    logic             tick, pclk_raw;
    logic             h_wrap, h_sync_q, h_act, v_wrap, v_sync_q, v_act;
    logic [ACT_W-1:0] h_idx, v_idx;
    logic             load;

    assign load = !video_en || (h_wrap && v_wrap);

    // Frame-aligned copy of the timing inputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h_cfg <= '0;
            v_cfg <= '0;
            div_q <= '0;
        end else if (load) begin
            h_cfg <= '{sync_w: h_sync, back_p: h_back, act_m1: h_act_m1, front_p: h_front};
            v_cfg <= '{sync_w: v_sync, back_p: v_back, act_m1: v_act_m1, front_p: v_front};
            div_q <= clk_div;
        end
    end

    tft_pclk_div #(.DW(DIV_W)) u_div (
        .clk(clk), .rst_n(rst_n), .run(video_en), .div(div_q),
        .tick(tick), .pclk_raw(pclk_raw)
    );

    tft_scan_axis #(.W(ACT_W), .PW(PORCH_W)) u_hax (
        .clk(clk), .rst_n(rst_n), .clear(!video_en), .step(tick),
        .sync_w(h_cfg.sync_w), .back_p(h_cfg.back_p),
        .act_m1(h_cfg.act_m1), .front_p(h_cfg.front_p),
        .wrap(h_wrap), .in_sync(h_sync_q), .in_act(h_act), .idx(h_idx)
    );

    tft_scan_axis #(.W(ACT_W), .PW(PORCH_W)) u_vax (
        .clk(clk), .rst_n(rst_n), .clear(!video_en), .step(h_wrap),
        .sync_w(v_cfg.sync_w), .back_p(v_cfg.back_p),
        .act_m1(v_cfg.act_m1), .front_p(v_cfg.front_p),
        .wrap(v_wrap), .in_sync(v_sync_q), .in_act(v_act), .idx(v_idx)
    );

    // Output gating and polarity.
    always_comb begin
        de_o    = video_en && h_act && v_act;
        pclk_o  = (video_en && pclk_raw) ^ pclk_inv;
        hsync_o = (video_en && h_sync_q) ^ hsync_inv;
        vsync_o = (video_en && v_sync_q) ^ vsync_inv;
        col_o   = de_o ? h_idx : '0;
        row_o   = de_o ? v_idx : '0;
    end
endmodule

// File: rtl/tft_timing_gen_chk.sv
// Checker for tft_timing_gen: port-level timing properties, bound to
// every instance of the top module.
module tft_timing_gen_chk
    import tft_timing_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             video_en,
    input logic             pclk_inv,
    input logic             hsync_inv,
    input logic             vsync_inv,
    input logic             pclk_o,
    input logic             hsync_o,
    input logic             vsync_o,
    input logic             de_o,
    input logic [ACT_W-1:0] col_o,
    input logic [ACT_W-1:0] row_o
);
    p_idle_when_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !video_en |-> (!de_o && hsync_o == hsync_inv && vsync_o == vsync_inv));

    p_pclk_rest_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !video_en |-> (pclk_o == pclk_inv));

    p_de_outside_sync_r8: assert property (@(posedge clk) disable iff (!rst_n)
        de_o |-> (hsync_o == hsync_inv && vsync_o == vsync_inv));

    p_pos_zero_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !de_o |-> (col_o == '0 && row_o == '0));

    p_col_steps_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (de_o && $past(de_o)) |-> (col_o == $past(col_o) || col_o == $past(col_o) + 1'b1));

    p_row_steady_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (de_o && $past(de_o)) |-> $stable(row_o));
endmodule

bind tft_timing_gen tft_timing_gen_chk u_chk (
    .clk(clk), .rst_n(rst_n), .video_en(video_en),
    .pclk_inv(pclk_inv), .hsync_inv(hsync_inv), .vsync_inv(vsync_inv),
    .pclk_o(pclk_o), .hsync_o(hsync_o), .vsync_o(vsync_o),
    .de_o(de_o), .col_o(col_o), .row_o(row_o)
);

// File: tb/tft_timing_gen_test.sv
module tft_timing_gen_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        video_en = 1'b0;
    logic [7:0]  clk_div = 8'd1;
    logic [10:0] h_act_m1 = 11'd4, v_act_m1 = 11'd2;
    logic [7:0]  h_front = 8'd1, h_back = 8'd3, h_sync = 8'd2;
    logic [7:0]  v_front = 8'd1, v_back = 8'd2, v_sync = 8'd1;
    logic        pclk_inv = 1'b0, hsync_inv = 1'b0, vsync_inv = 1'b0;
    logic        pclk_o, hsync_o, vsync_o, de_o;
    logic [10:0] col_o, row_o;

    int n_chk = 0, n_bad = 0, cyc = 0;

    always #4 clk = ~clk;   // 125 MHz

    tft_timing_gen uut (.*);

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    // Watchdog.
    always @(negedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d cycles, expected fewer", cyc);
            finish_run();
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Active level of a signal, independent of polarity.
    function automatic logic act_of(input int w);
        case (w)
            0: return pclk_o ^ pclk_inv;
            1: return hsync_o ^ hsync_inv;
            2: return vsync_o ^ vsync_inv;
            default: return de_o;
        endcase
    endfunction

    task automatic wait_lvl(input int w, input logic lv, output int n);
        n = 0;
        while (act_of(w) != lv) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic run_len(input int w, output int n);
        int d;
        wait_lvl(w, 1'b0, d);
        wait_lvl(w, 1'b1, d);
        wait_lvl(w, 1'b0, n);
    endtask

    task automatic period(input int w, output int n);
        int a, b;
        wait_lvl(w, 1'b0, a);
        wait_lvl(w, 1'b1, a);
        wait_lvl(w, 1'b0, a);
        wait_lvl(w, 1'b1, b);
        n = a + b;
    endtask

    task automatic gap(input int a, input int b, output int n);
        int d;
        wait_lvl(a, 1'b1, d);
        wait_lvl(a, 1'b0, d);
        wait_lvl(b, 1'b1, n);
    endtask

    task automatic restart();
        video_en = 1'b0;
        repeat (3) @(negedge clk);
        video_en = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset_idle();
        chk(de_o == 0 && col_o == 0 && row_o == 0, "R6 idle de/col/row", int'(de_o), 0);
        chk(hsync_o == 0 && vsync_o == 0, "R6 idle syncs", int'({hsync_o, vsync_o}), 0);
        chk(pclk_o == 0, "R1 pclk rest", int'(pclk_o), 0);
    endtask

    task automatic t_pclk(input int dv);
        int p, h;
        clk_div = 8'(dv);
        restart();
        period(0, p);
        chk(p == 2 * (dv + 1), "R1 pclk period", p, 2 * (dv + 1));
        run_len(0, h);
        chk(h == dv + 1, "R1 pclk high", h, dv + 1);
    endtask

    task automatic t_line();
        int n;
        clk_div = 8'd1;
        restart();
        chk(act_of(1) && act_of(2), "R6 start with syncs", int'({hsync_o, vsync_o}), 3);
        run_len(1, n); chk(n == 8,  "R3 hsync width", n, 8);
        period(1, n);  chk(n == 44, "R3 line period", n, 44);
        run_len(3, n); chk(n == 20, "R2 de run", n, 20);
        gap(1, 3, n);  chk(n == 12, "R3 back porch", n, 12);
        gap(3, 1, n);  chk(n == 4,  "R3 front porch", n, 4);
    endtask

    task automatic t_frame();
        int n, lines;
        logic prev;
        restart();
        run_len(2, n); chk(n == 44,  "R4 vsync width", n, 44);
        period(2, n);  chk(n == 308, "R4 frame period", n, 308);
        // Count enabled lines in one frame; check de never during vsync.
        wait_lvl(2, 1'b0, n);
        lines = 0; prev = 1'b0;
        while (!act_of(2)) begin
            if (de_o && !prev) lines++;
            prev = de_o;
            @(negedge clk);
        end
        chk(lines == 3, "R2 lines per frame", lines, 3);
        while (act_of(2)) begin
            chk(!de_o, "R8 de during vsync", int'(de_o), 0);
            @(negedge clk);
        end
    endtask

    task automatic t_scan_order();
        int n, last_col;
        restart();
        for (int ln = 0; ln < 3; ln++) begin
            wait_lvl(3, 1'b1, n);
            chk(col_o == 0, "R7 first col", int'(col_o), 0);
            chk(row_o == 11'(ln), "R7 row", int'(row_o), ln);
            last_col = 0;
            while (de_o) begin
                last_col = int'(col_o);
                @(negedge clk);
            end
            chk(last_col == 4, "R7 last col", last_col, 4);
            chk(col_o == 0 && row_o == 0, "R7 zero outside de", int'(col_o), 0);
        end
    endtask

    task automatic t_polarity();
        int n;
        pclk_inv = 1'b1; hsync_inv = 1'b1; vsync_inv = 1'b1;
        video_en = 1'b0;
        @(negedge clk);
        chk(pclk_o && hsync_o && vsync_o, "R5 inverted rest high",
            int'({pclk_o, hsync_o, vsync_o}), 7);
        restart();
        chk(!hsync_o && !vsync_o, "R5 active low start", int'({hsync_o, vsync_o}), 0);
        run_len(1, n); chk(n == 8, "R5 inverted hsync width", n, 8);
        period(0, n);  chk(n == 4, "R5 inverted pclk period", n, 4);
        pclk_inv = 1'b0; hsync_inv = 1'b0; vsync_inv = 1'b0;
    endtask

    task automatic t_disable();
        int n;
        restart();
        wait_lvl(3, 1'b1, n);
        video_en = 1'b0;
        #1;
        chk(!de_o && !hsync_o && !vsync_o && !pclk_o, "R6 off mid-frame",
            int'({de_o, hsync_o, vsync_o, pclk_o}), 0);
        repeat (20) begin
            @(negedge clk);
            chk(!de_o && col_o == 0, "R6 stays idle", int'(de_o), 0);
        end
    endtask

    task automatic t_frame_aligned();
        int n;
        restart();
        wait_lvl(2, 1'b0, n);
        wait_lvl(2, 1'b1, n);
        h_act_m1 = 11'd2;
        run_len(3, n); chk(n == 20, "R9 old width kept", n, 20);
        wait_lvl(2, 1'b0, n);
        wait_lvl(2, 1'b1, n);
        run_len(3, n); chk(n == 12, "R9 new width next frame", n, 12);
        h_act_m1 = 11'd4;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset_idle();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_idle();
        t_pclk(0);
        t_pclk(3);
        t_pclk(1);
        t_line();
        t_frame();
        t_scan_order();
        t_polarity();
        t_disable();
        t_frame_aligned();
        finish_run();
    end
endmodule